// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog peripheral on an APB-style register bus. When it is armed, a counter measures a first interval. The end of that interval sets a sticky flag and, if allowed, raises an interrupt. A second interval then starts. If software has not restarted the counter by the time the second interval ends, the block drives a one-clock reset request. The counter advances on every bus clock, or on each rising edge of a slower external clock after synchronisation.

The control and restart registers are guarded by a single-use key. Software first writes the unlock key and then, as the very next bus write, the protected register. A restart only takes effect when it carries the restart code. The interrupt interval comes from a non-linear table of power-of-two exponents. The reset interval is a plain power of two.

The sequencer has four states. ST_OFF is the disabled state. ST_INT_WAIT counts the first interval. ST_RST_WAIT counts the second interval. ST_HOLD is entered after the second interval and stays quiet. The transitions are:
- OFF→INT_WAIT when the enable bit is seen.
- INT_WAIT→RST_WAIT when the first interval is reached.
- RST_WAIT→HOLD when the second interval is reached.
- any state→INT_WAIT on a valid restart.
- any state→OFF when the enable bit is cleared.

Top module: `wdog_timer`

## Requirements
- R1: Offset 0x00 returns the constant identification word and ignores writes. Offsets 0x14, 0x18 and any unmapped offset read as zero. Register bits above the defined fields read as zero.
- R2: A write to control (0x10) or restart (0x14) has no effect unless the write immediately before it wrote 0x5AA5 to the unlock register (0x18).
- R3: An unlock opens exactly one following write. Any bus write that is not itself the unlock key cancels it, including a write to status or ID.
- R4: A keyed write of 0xCAFE to offset 0x14 returns the sequencer to the first interval with a zero count, so the reset request comes 2^e1 + 2^e2 clocks after that write. Any other value restarts nothing. A restart leaves the status flag unchanged.
- R5: The control fields are: bit 0 enable, bit 1 clock select, bit 2 interrupt enable, bit 3 reset enable, [7:4] interrupt code, [10:8] reset code. A control write with bit 0 clear also clears bit 3 and stores the other fields as written.
- R6: The interrupt interval is 2^e clocks. Interrupt codes 0..15 map to e = 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31. With the bus clock selected, the flag sets 2^e + 1 clocks after the enabling write.
- R7: Status bit 0 is set at the end of the first interval and stays set. Writing 1 to it clears it, and writing 0 has no effect. The interrupt output equals the flag AND the interrupt-enable bit.
- R8: When the first interval ends, a second interval of 2^(7+n) clocks starts, where n is the reset code. At its end, wdt_rst_o is high for exactly one clock, but only if reset enable is set.
- R9: With bit 1 = 1 the counter advances every bus clock. With bit 1 = 0 it advances once per synchronised rising edge of ext_clk.
- R10: After the second interval the sequencer holds without further reset requests until it is restarted or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Slow external count clock, asynchronous |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request (level) |
| wdt_rst_o | output | 1 | One-clock reset request |

## Verification
The assertions assume that every bus transfer has a setup cycle followed by an access cycle, and that ext_clk is slow against clk, holding each level for several bus clocks. The stimulus keeps to both conditions:
- It drives two-phase transfers on falling edges.
- It toggles ext_clk every five bus clocks.
- It clears the enable bit before changing an interval code, so that each measured interval starts from a known count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] OFS_ID      = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_CTRL    = 5'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_RESTART = 5'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_UNLOCK  = 5'h18;
    localparam logic [REG_ADDR_W-1:0] OFS_STATUS  = 5'h1C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0000_5AA5;
    localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_CAFE;

    // Packed MSB first: [10:8] rst_code, [7:4] int_code, [3] rst_en,
    // [2] int_en, [1] bus_clk_sel, [0] enable
    typedef struct packed {
        logic [2:0] rst_code;
        logic [3:0] int_code;
        logic       rst_en;
        logic       int_en;
        logic       bus_clk_sel;
        logic       enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_INT_WAIT = 2'd1,
        ST_RST_WAIT = 2'd2,
        ST_HOLD     = 2'd3
    } wd_state_e;

    // First-interval exponent: 6, 8, then 10..15, then odd 17..31
    function automatic logic [4:0] int_exponent(input logic [3:0] code);
        logic [4:0] e;
        if (code == 4'd0)
            e = 5'd6;
        else if (code == 4'd1)
            e = 5'd8;
        else if (code < 4'd8)
            e = 5'({1'b0, code} + 5'd8);
        else
            e = 5'({code, 1'b1});
        return e;
    endfunction

    function automatic logic [4:0] rst_exponent(input logic [2:0] code);
        return 5'({2'b00, code} + 5'd7);
    endfunction

endpackage

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic bus_clk_sel,
    output logic tick_o
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[CHAIN_W-2:0], ext_clk};
    end

    logic ext_rise;
    assign ext_rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

    generate
        if (SYNC_STAGES >= 2) begin : g_sel
            assign tick_o = bus_clk_sel ? 1'b1 : ext_rise;
        end else begin : g_sel_min
            assign tick_o = bus_clk_sel | ext_rise;
        end
    endgenerate

    // R9: an external tick never repeats on back-to-back clocks
    assert_ext_tick_spaced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_clk_sel && ext_rise) |=> !ext_rise);

endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0002_0100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [REG_ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0]     pwdata,
    output logic [DATA_W-1:0]     prdata,
    input  logic                  stage1_done_i,
    output ctrl_t                 ctrl_o,
    output logic                  restart_o,
    output logic                  flag_o
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    logic  key_open_q;
    ctrl_t ctrl_q;
    logic  flag_q;

    logic  wr_stb;
    logic  hit_ctrl, hit_restart, hit_unlock, hit_status;
    logic  ctrl_wr, flag_clr;
    ctrl_t ctrl_new;

    always_comb begin
        wr_stb      = psel & penable & pwrite;
        hit_ctrl    = (paddr == OFS_CTRL);
        hit_restart = (paddr == OFS_RESTART);
        hit_unlock  = (paddr == OFS_UNLOCK);
        hit_status  = (paddr == OFS_STATUS);
        ctrl_wr     = wr_stb & hit_ctrl & key_open_q;
        restart_o   = wr_stb & hit_restart & key_open_q & (pwdata == RESTART_KEY);
        flag_clr    = wr_stb & hit_status & pwdata[0];
        ctrl_new    = ctrl_t'(pwdata[CTRL_W-1:0]);
        if (!ctrl_new.enable)
            ctrl_new.rst_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            key_open_q <= 1'b0;
        else if (wr_stb)
            key_open_q <= hit_unlock & (pwdata == UNLOCK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (stage1_done_i)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    always_comb begin
        case (paddr)
            OFS_ID:     prdata = ID_VALUE;
            OFS_CTRL:   prdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_STATUS: prdata = {{(DATA_W-1){1'b0}}, flag_q};
            default:    prdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign flag_o = flag_q;

    // R2: control changes only right after an open key
    assert_ctrl_keyed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(key_open_q));

    // R3: any non-unlock write closes the key
    assert_key_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !hit_unlock) |=> !key_open_q);

    // R7: flag falls only after a write-one-to-clear
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_stb && hit_status && pwdata[0]));

endmodule

// File: rtl/wdog_sequencer.sv
module wdog_sequencer
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  ctrl_t ctrl_i,
    input  logic  restart_i,
    output logic  stage1_done_o,
    output logic  wdt_rst_o
);
    localparam int unsigned LIM_W = CNT_W + 1;

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rst_q, rst_d;
    logic [LIM_W-1:0] int_lim, rst_lim, cnt_ext;
    logic             int_reached, rst_reached;

    always_comb begin
        int_lim     = LIM_W'(1) << int_exponent(ctrl_i.int_code);
        rst_lim     = LIM_W'(1) << rst_exponent(ctrl_i.rst_code);
        cnt_ext     = {1'b0, cnt_q};
        int_reached = (cnt_ext >= int_lim - LIM_W'(1));
        rst_reached = (cnt_ext >= rst_lim - LIM_W'(1));
    end

    // next state and counter
    always_comb begin
        state_d       = state_q;
        cnt_d         = cnt_q;
        rst_d         = 1'b0;
        stage1_done_o = 1'b0;
        if (!ctrl_i.enable) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else if (restart_i) begin
            state_d = ST_INT_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_INT_WAIT;
                    cnt_d   = '0;
                end
                ST_INT_WAIT: begin
                    if (tick_i) begin
                        if (int_reached) begin
                            stage1_done_o = 1'b1;
                            state_d       = ST_RST_WAIT;
                            cnt_d         = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_RST_WAIT: begin
                    if (tick_i) begin
                        if (rst_reached) begin
                            rst_d   = ctrl_i.rst_en;
                            state_d = ST_HOLD;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rst_q <= 1'b0;
        else
            rst_q <= rst_d;
    end

    assign wdt_rst_o = rst_q;

    // R8: reset request lasts one clock
    assert_rst_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);

    // R8: reset request only with reset stage enabled
    assert_rst_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_q) |-> $past(ctrl_i.rst_en));

    // R4: a restart while enabled returns to the first interval
    assert_restart_stage1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && ctrl_i.enable) |=> (state_q == ST_INT_WAIT));

    // R10: holding state stays quiet
    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> !rst_q);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h0002_0100,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_clk,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [4:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        irq_o,
    output logic        wdt_rst_o
);
    ctrl_t ctrl;
    logic  restart, flag, stage1_done, tick;

    wdog_regfile #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .stage1_done_i(stage1_done), .ctrl_o(ctrl), .restart_o(restart),
        .flag_o(flag)
    );

    wdog_tickgen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .bus_clk_sel(ctrl.bus_clk_sel), .tick_o(tick)
    );

    wdog_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctrl_i(ctrl),
        .restart_i(restart), .stage1_done_o(stage1_done),
        .wdt_rst_o(wdt_rst_o)
    );

    assign irq_o = flag & ctrl.int_en;

    // R7: interrupt only while the flag is set
    assert_irq_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, wdt_rst_o;

    localparam logic [31:0] ID_WORD = 32'h0002_0100;

    always #2.5 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    int    checks = 0;
    int    errors = 0;
    longint cyc = 0;
    int    rst_pulses = 0;

    typedef struct {
        longint due;
        bit     is_rst;
        logic   val;
        string  tag;
    } exp_t;
    exp_t sbq[$];

    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        repeat (5) @(negedge clk);
        ext_clk = ~ext_clk;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expectations as their cycle arrives
    always @(negedge clk) begin
        if (rst_n && wdt_rst_o) rst_pulses++;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.due < cyc)
                check({e.tag, " missed"}, 32'd1, 32'd0);
            else
                check(e.tag, {31'd0, e.is_rst ? wdt_rst_o : irq_o}, {31'd0, e.val});
        end
    end

    task automatic expect_at(input longint off, input bit is_rst, input logic v, input string tag);
        exp_t e;
        e.due = cyc + off; e.is_rst = is_rst; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic keyed_write(input logic [4:0] a, input logic [31:0] d);
        bus_write(5'h18, 32'h5AA5);
        bus_write(a, d);
    endtask

    task automatic read_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R7 reset irq", {31'd0, irq_o}, 32'd0);
        check("R8 reset rst", {31'd0, wdt_rst_o}, 32'd0);
        read_check(5'h10, 32'h0, "R5 reset ctrl");
        read_check(5'h1C, 32'h0, "R7 reset status");
        // R1
        read_check(5'h00, ID_WORD, "R1 id");
        keyed_write(5'h00, 32'hFFFF_FFFF);
        read_check(5'h00, ID_WORD, "R1 id read-only");
        read_check(5'h04, 32'h0, "R1 unmapped");
        read_check(5'h18, 32'h0, "R1 unlock reads zero");
        // R2: control write without key
        bus_write(5'h10, 32'h0000_000F);
        read_check(5'h10, 32'h0, "R2 unkeyed ctrl ignored");
        // R3: key cancelled by an intervening status write
        bus_write(5'h18, 32'h5AA5);
        bus_write(5'h1C, 32'h0);
        bus_write(5'h10, 32'h0000_000F);
        read_check(5'h10, 32'h0, "R3 key cancelled");
        // R5: disable write clears reset enable
        keyed_write(5'h10, 32'h0000_02AC);
        read_check(5'h10, 32'h0000_02A4, "R5 disable clears bit3");
        bus_write(5'h10, 32'h0000_07FF);
        read_check(5'h10, 32'h0000_02A4, "R3 key single use");

        // R6/R8 main sequence, bus clock, codes 0/0
        keyed_write(5'h10, 32'h0000_000F);
        expect_at(64, 0, 1'b0, "R6 irq before 2^6+1");
        expect_at(65, 0, 1'b1, "R6 irq at 2^6+1");
        expect_at(192, 1, 1'b0, "R8 rst before");
        expect_at(193, 1, 1'b1, "R8 rst pulse");
        expect_at(194, 1, 1'b0, "R8 rst one clock");
        drain();
        // R10 hold, R2 unkeyed restart
        base = rst_pulses;
        bus_write(5'h14, 32'h0000_CAFE);
        repeat (300) @(negedge clk);
        check("R10 hold no pulse / R2 unkeyed restart", rst_pulses, base);
        // R4 restart with wrong value in between
        keyed_write(5'h14, 32'h0000_CAFE);
        expect_at(191, 1, 1'b0, "R4 rst before");
        expect_at(192, 1, 1'b1, "R4 rst after restart");
        repeat (30) @(negedge clk);
        keyed_write(5'h14, 32'h0000_1234);
        read_check(5'h1C, 32'h1, "R4 restart keeps flag");
        drain();
        // R7 write-one-to-clear
        bus_write(5'h1C, 32'h0);
        read_check(5'h1C, 32'h1, "R7 write zero keeps flag");
        bus_write(5'h1C, 32'h1);
        read_check(5'h1C, 32'h0, "R7 write one clears");
        @(negedge clk);
        check("R7 irq cleared", {31'd0, irq_o}, 32'd0);

        // R6/R8 codes 1/1 with interrupt disabled
        keyed_write(5'h10, 32'h0);
        keyed_write(5'h10, 32'h0000_011B);
        expect_at(300, 0, 1'b0, "R7 irq masked");
        expect_at(512, 1, 1'b0, "R8 code1 before");
        expect_at(513, 1, 1'b1, "R6 R8 code1 timing");
        drain();
        read_check(5'h1C, 32'h1, "R7 flag set while masked");

        // R8 reset stage disabled
        keyed_write(5'h10, 32'h0);
        bus_write(5'h1C, 32'h1);
        keyed_write(5'h10, 32'h0000_0007);
        base = rst_pulses;
        expect_at(65, 0, 1'b1, "R8 irq without reset stage");
        drain();
        repeat (300) @(negedge clk);
        check("R8 no pulse when disabled", rst_pulses, base);

        // R9 external clock
        keyed_write(5'h10, 32'h0);
        bus_write(5'h1C, 32'h1);
        keyed_write(5'h10, 32'h0000_0005);
        expect_at(600, 0, 1'b0, "R9 ext slower than bus");
        expect_at(700, 0, 1'b1, "R9 ext expiry");
        drain();

        finish_run();
    end
endmodule